// File: doc/BRIEF.md
# SHA-512 Message Schedule Unit

This block produces four new 64-bit words of the SHA-512 message schedule at a time. The work is split into two instruction-like steps, and an opcode on each request picks the step. The pre-step adds the small sigma0 of each word's successor to that word. The final step takes those partial sums, together with the two most recent schedule words, and completes four new words with the small sigma1. In the final step the upper two lanes depend on the lower two lanes that the same step has just produced.

A request is presented with a valid/ready handshake. The request carries the opcode and two 256-bit operands. Each accepted request gives one registered 256-bit result, flagged by a result-valid signal. The downstream side holds that result with its own ready signal. Round constants and the compression rounds belong to other blocks.

Top module: `sha512_msg_sched`

## Requirements
- R1: With opcode 0, result word i equals operand-A word i plus sigma0 of its successor, modulo 2^64. The successor of word i is A word i+1 for i = 0..2. The successor of word 3 is B word 0.
- R2: sigma0(x) = ROR(x,1) ^ ROR(x,8) ^ (x >> 7), with a logical shift. For example, sigma0(1) = 64'h8100_0000_0000_0000.
- R3: With opcode 1, the result words are built in this order: w16 = A0 + sigma1(B2), w17 = A1 + sigma1(B3), w18 = A2 + sigma1(w16), w19 = A3 + sigma1(w17). All sums are modulo 2^64.
- R4: sigma1(x) = ROR(x,19) ^ ROR(x,61) ^ (x >> 6). For example, sigma1(1) = 64'h0000_2000_0000_0008.
- R5: With opcode 1, words 0 and 1 of operand B have no effect on the result. With opcode 0, bits 255:64 of operand B have no effect on the result.
- R6: Word i of any 256-bit vector occupies bits 64*i+63 down to 64*i. The results pack w16..w19 into words 0..3 in that order.
- R7: res_valid_o is high in the cycle after an accepted request (req_valid_i and req_ready_o both high). It drops after a cycle with res_ready_i high and no new acceptance.
- R8: req_ready_o is high exactly when res_valid_o is low or res_ready_i is high.
- R9: While res_valid_o is high and res_ready_i is low, res_data_o and res_valid_o hold their values.
- R10: rst_ni low clears res_valid_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is offered |
| req_ready_o | output | 1 | The unit can take a request this cycle |
| req_op_i | input | 1 | 0 selects the sigma0 pre-step, 1 selects the sigma1 final step |
| opa_i | input | 256 | Operand A, four words |
| opb_i | input | 256 | Operand B: word 0 is the extra word for the pre-step; words 2 and 3 are the two prior schedule words for the final step |
| res_valid_o | output | 1 | The result register holds an unconsumed result |
| res_ready_i | input | 1 | The consumer takes the result |
| res_data_o | output | 256 | Registered result |

## Verification
Two things can happen in the same cycle: the consumer retires the held result, and a new request is accepted into the same register. The bench provokes this with long runs where request valid and result ready toggle at random and often stay high together. That drives back-to-back loads through a full register, and it mixes in stall runs where a waiting request must not be taken. A behavioural model tracks occupancy and contents on every clock. It judges each cycle's ready, valid and data, so it would catch a lost result, a duplicated result, or an overwrite during a stall.

// File: rtl/sha512_ms_pkg.sv
package sha512_ms_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned LANES  = 4;
  localparam int unsigned VEC_W  = WORD_W * LANES;

  localparam int unsigned S0_R1 = 1;
  localparam int unsigned S0_R2 = 8;
  localparam int unsigned S0_SH = 7;
  localparam int unsigned S1_R1 = 19;
  localparam int unsigned S1_R2 = 61;
  localparam int unsigned S1_SH = 6;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    OP_PRE = 1'b0,
    OP_FIN = 1'b1
  } ms_op_e;

  function automatic word_t rotr(word_t x, int unsigned n);
    int unsigned k;
    k = n % WORD_W;
    if (k == 0) return x;
    return (x >> k) | (x << (WORD_W - k));
  endfunction

  function automatic word_t ssig0(word_t x);
    return rotr(x, S0_R1) ^ rotr(x, S0_R2) ^ (x >> S0_SH);
  endfunction

  function automatic word_t ssig1(word_t x);
    return rotr(x, S1_R1) ^ rotr(x, S1_R2) ^ (x >> S1_SH);
  endfunction
endpackage

// File: rtl/ms_pre_step.sv
module ms_pre_step
  import sha512_ms_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic [N_LANES*WORD_W-1:0] src_i,
  input  word_t                     ext_i,
  output logic [N_LANES*WORD_W-1:0] sum_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    word_t succ;
    if (l == N_LANES - 1) begin : g_top
      assign succ = ext_i;
    end else begin : g_mid
      assign succ = src_i[(l+1)*WORD_W +: WORD_W];
    end
    assign sum_o[l*WORD_W +: WORD_W] = src_i[l*WORD_W +: WORD_W] + ssig0(succ);
  end
endmodule

// File: rtl/ms_final_step.sv
module ms_final_step
  import sha512_ms_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic [N_LANES*WORD_W-1:0] part_i,
  input  word_t                     prev2_i,
  input  word_t                     prev1_i,
  output logic [N_LANES*WORD_W-1:0] word_o
);
  // chain[k+2] depends on chain[k]: lanes 2,3 see freshly built lanes 0,1
  word_t chain [N_LANES+2];

  assign chain[0] = prev2_i;
  assign chain[1] = prev1_i;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign chain[l+2] = part_i[l*WORD_W +: WORD_W] + ssig1(chain[l]);
    assign word_o[l*WORD_W +: WORD_W] = chain[l+2];
  end
endmodule

// File: rtl/ms_out_reg.sv
module ms_out_reg #(
  parameter int unsigned DW = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          drop_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/sha512_msg_sched.sv
module sha512_msg_sched
  import sha512_ms_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_op_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [VEC_W-1:0] res_data_o
);
  logic [VEC_W-1:0] pre_sum;
  logic [VEC_W-1:0] fin_word;
  logic [VEC_W-1:0] next_res;
  logic             accept;
  logic             unused_opb;

  assign unused_opb = ^opb_i[2*WORD_W-1:WORD_W];

  ms_pre_step #(.N_LANES(LANES)) u_pre (
    .src_i (opa_i),
    .ext_i (opb_i[WORD_W-1:0]),
    .sum_o (pre_sum)
  );

  ms_final_step #(.N_LANES(LANES)) u_fin (
    .part_i  (opa_i),
    .prev2_i (opb_i[2*WORD_W +: WORD_W]),
    .prev1_i (opb_i[3*WORD_W +: WORD_W]),
    .word_o  (fin_word)
  );

  assign next_res    = (ms_op_e'(req_op_i) == OP_FIN) ? fin_word : pre_sum;
  assign req_ready_o = ~res_valid_o | res_ready_i;
  assign accept      = req_valid_i & req_ready_o;

  ms_out_reg #(.DW(VEC_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .drop_i  (res_ready_i),
    .d_i     (next_res),
    .q_o     (res_data_o),
    .valid_o (res_valid_o)
  );
endmodule

// File: rtl/sha512_msg_sched_chk.sv
module sha512_msg_sched_chk
  import sha512_ms_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_op_i,
  input logic [VEC_W-1:0] opa_i,
  input logic [VEC_W-1:0] opb_i,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [VEC_W-1:0] res_data_o
);
  logic take;
  assign take = req_valid_i && req_ready_o;

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> res_valid_o); // R7

  AST_RETIRE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i && !req_valid_i) |=> !res_valid_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o))); // R9

  AST_BLOCK_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |-> !req_ready_o); // R8

  AST_OPEN_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> req_ready_o); // R8

  AST_PRE_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && req_op_i == 1'b0) |=>
      res_data_o[WORD_W-1:0] == $past(opa_i[WORD_W-1:0] + ssig0(opa_i[2*WORD_W-1:WORD_W]))); // R1

  AST_FIN_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && req_op_i == 1'b1) |=>
      res_data_o[WORD_W-1:0] == $past(opa_i[WORD_W-1:0] + ssig1(opb_i[3*WORD_W-1:2*WORD_W]))); // R3

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!res_valid_o); // R10
    end
  end
endmodule

bind sha512_msg_sched sha512_msg_sched_chk u_chk (.*);

// File: tb/sha512_msg_sched_bench.sv
module sha512_msg_sched_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_op_i = 1'b0;
  logic [255:0] opa_i = '0;
  logic [255:0] opb_i = '0;
  logic         res_ready_i = 1'b0;
  logic         req_ready_o;
  logic         res_valid_o;
  logic [255:0] res_data_o;

  int    n_cmp = 0;
  int    n_mis = 0;
  bit    done = 1'b0;
  bit    m_val = 1'b0;
  logic [255:0] m_dat = '0;
  string m_tag = "R1";

  always #10 clk_i = ~clk_i;

  sha512_msg_sched u_sha512_msg_sched (.*);

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [63:0] s0(logic [63:0] x);
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [63:0] s1(logic [63:0] x);
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction

  function automatic logic [255:0] ref_pre(logic [255:0] a, logic [255:0] b);
    logic [255:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] nx;
      nx = (i == 3) ? b[63:0] : a[64*(i+1) +: 64];
      r[64*i +: 64] = a[64*i +: 64] + s0(nx);
    end
    return r;
  endfunction

  function automatic logic [255:0] ref_fin(logic [255:0] a, logic [255:0] b);
    logic [63:0] w [6];
    logic [255:0] r;
    w[0] = b[191:128];
    w[1] = b[255:192];
    for (int i = 0; i < 4; i++) begin
      w[i+2] = a[64*i +: 64] + s1(w[i]);
      r[64*i +: 64] = w[i+2];
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input bit v, input bit op, input logic [255:0] a, input logic [255:0] b,
                      input bit rdy, input string tag);
    bit m_rdy;
    req_valid_i = v;
    req_op_i    = op;
    opa_i       = a;
    opb_i       = b;
    res_ready_i = rdy;
    #1;
    m_rdy = !m_val || rdy;
    check(req_ready_o == m_rdy, "R8", {255'b0, req_ready_o}, {255'b0, m_rdy});
    @(posedge clk_i);
    if (v && m_rdy) begin
      m_val = 1'b1;
      m_dat = op ? ref_fin(a, b) : ref_pre(a, b);
      m_tag = tag;
    end else if (rdy) begin
      m_val = 1'b0;
    end
    @(negedge clk_i);
    check(res_valid_o == m_val, "R7", {255'b0, res_valid_o}, {255'b0, m_val});
    if (m_val) check(res_data_o == m_dat, m_tag, res_data_o, m_dat);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_mis++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, r0, r1;
    repeat (3) @(negedge clk_i);
    check(res_valid_o == 1'b0, "R10", {255'b0, res_valid_o}, 256'b0);
    check(req_ready_o == 1'b1, "R8", {255'b0, req_ready_o}, 256'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: sigma0 of a single low bit lands in word 3
    tick(1, 0, '0, 256'h1, 1, "R2");
    check(res_data_o == {64'h8100_0000_0000_0000, 192'b0}, "R2", res_data_o,
          {64'h8100_0000_0000_0000, 192'b0});
    // R4: sigma1 of a single low bit in lane 0
    tick(1, 1, '0, {64'h0, 64'h1, 128'h0}, 1, "R4");
    check(res_data_o[63:0] == 64'h0000_2000_0000_0008, "R4", {192'b0, res_data_o[63:0]},
          {192'b0, 64'h0000_2000_0000_0008});
    // R6: distinct lanes packed in order
    tick(1, 0, {64'h4, 64'h3, 64'h2, 64'h1}, 256'h5, 1, "R6");
    tick(1, 1, {64'h4, 64'h3, 64'h2, 64'h1}, {64'h6, 64'h5, 128'h0}, 1, "R6");
    // R1 / R3: wrap-around with all-ones operands
    tick(1, 0, '1, '1, 1, "R1");
    tick(1, 1, '1, '1, 1, "R3");

    // R5: ignored words of operand B
    a = rnd256();
    b = rnd256();
    tick(1, 1, a, b, 1, "R5");
    r0 = res_data_o;
    tick(1, 1, a, {b[255:128], ~b[127:0]}, 1, "R5");
    r1 = res_data_o;
    check(r0 == r1, "R5", r1, r0);
    tick(1, 0, a, b, 1, "R5");
    r0 = res_data_o;
    tick(1, 0, a, {~b[255:64], b[63:0]}, 1, "R5");
    r1 = res_data_o;
    check(r0 == r1, "R5", r1, r0);

    // R9: stall with requests pending
    tick(1, 0, rnd256(), rnd256(), 0, "R9");
    for (int i = 0; i < 6; i++) tick(1, i[0], rnd256(), rnd256(), 0, "R9");
    tick(0, 0, '0, '0, 1, "R9");
    tick(0, 0, '0, '0, 1, "R7");

    // concurrent retire and accept, random mix
    for (int i = 0; i < 400; i++) begin
      bit op;
      op = $urandom_range(0, 1);
      tick($urandom_range(0, 3) != 0, op, rnd256(), rnd256(), $urandom_range(0, 3) != 0,
           op ? "R3" : "R1");
    end

    // R10: asynchronous reset while a result is held
    tick(1, 0, rnd256(), rnd256(), 0, "R10");
    rst_ni = 1'b0;
    #1;
    m_val = 1'b0;
    check(res_valid_o == 1'b0, "R10", {255'b0, res_valid_o}, 256'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(1, 1, rnd256(), rnd256(), 1, "R3");
    tick(0, 0, '0, '0, 1, "R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule